// File: doc/BRIEF.md
# Single-Wire Pulse-Width Bus Host

This block is the master side of a single-wire, return-to-one serial bus. The one wire has a pull-up resistor. Both ends can only pull it low, through open-drain drivers. A local client places a request: a 7-bit command, a read/write flag and, for a write, one data byte. The host opens the transfer with a break. It then sends one command byte as pulse-width-coded time slots. Last, it either sends the data byte or collects the byte that the responder drives back. Each transaction moves exactly one byte. The client issues a new request for every byte, and each one repeats the break and the command.

All timing is counted in clock cycles and set by parameters: break, break recovery, slot length, the two low-pulse widths, the receive sample point and the receive timeout. The raw line input passes through a synchroniser before the block uses it. A received bit is decoded by sampling the synchronised line a fixed number of cycles after its falling edge is seen.

A single state machine runs the transfer through these states:
- `ST_IDLE`: moves to `ST_BREAK` when a request is accepted.
- `ST_BREAK`: moves to `ST_RECOV` when the break time ends.
- `ST_RECOV`: moves to `ST_TX_SLOT` when the recovery time ends.
- `ST_TX_SLOT`: stays put for each following bit. After the last slot it moves to `ST_FINISH` for a write, or to `ST_RX_WAIT` for a read.
- `ST_RX_WAIT`: moves to `ST_RX_SAMPLE` on a falling edge, or to `ST_FINISH` on timeout.
- `ST_RX_SAMPLE`: moves back to `ST_RX_WAIT` after a sample, or to `ST_FINISH` after the eighth bit.
- `ST_FINISH`: moves to `ST_IDLE`.

Top module: `pw_serial_host`

## Requirements
- R1: After reset `line_oe`, `busy`, `done` and `err_timeout` are 0 and `rd_data` is 0.
- R2: A request (`req_valid` high) is accepted only while `busy` is 0, and `busy` is 1 in the next cycle. Request inputs seen while `busy` is 1 have no effect on the transfer in flight.
- R3: Starting the cycle after acceptance, `line_oe` is 1 for exactly BREAK_CYC cycles (the break). It is then 0 for exactly RECOV_CYC cycles (the recovery).
- R4: The command byte carries the command in bits 0 to 6 and the flag in bit 7, where 1 means read and 0 means write. It is sent least significant bit first.
- R5: Every host slot lasts SLOT_CYC cycles. `line_oe` is 1 for the first LOW1_CYC cycles for a 1 bit, or the first LOW0_CYC cycles for a 0 bit, and 0 for the rest of the slot.
- R6: For a write, eight more host slots follow the command, carrying `req_wdata` least significant bit first. `done` pulses in the cycle after the last slot.
- R7: For a read, the host keeps `line_oe` at 0 after the command. Each bit is sampled SAMPLE_CYC cycles after a falling edge is seen on the synchronised line; low reads as 0 and high as 1. Bits fill the byte least significant first, and `rd_data` holds the byte when `done` pulses.
- R8: If no falling edge arrives within TIMEOUT_CYC cycles while waiting for a read bit, the transfer ends: `done` pulses with `err_timeout` set, and `rd_data` keeps its old value.
- R9: `done` is a one-cycle pulse and is the last cycle in which `busy` is 1.
- R10: `err_timeout` stays set while idle and is cleared when the next request is accepted.
- R11: A write transaction leaves `rd_data` unchanged.
- R12: `line_oe` is 0 whenever `busy` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, taken while idle |
| req_cmd | input | 7 | Command code |
| req_rd | input | 1 | 1 = read, 0 = write |
| req_wdata | input | 8 | Byte to write |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle end-of-transaction pulse |
| rd_data | output | 8 | Last byte read successfully |
| err_timeout | output | 1 | Last read aborted on timeout |
| line_oe | output | 1 | 1 pulls the wire low; 0 releases it |
| line_in | input | 1 | Raw wire level (asynchronous) |

## Verification
The bench measures every low and high run on the wire to the exact cycle. A mistake in bit order, in the position of the flag, or in the pulse widths therefore shows up as a wrong run length. Requests are held high across the break, so a host that re-latches its request while busy would send a different command. Reads cover three cases: a full response, a silent responder, and a responder that stops after three bits. A host that does not time out would hang the run. A host that writes partial bytes into `rd_data`, or that clears the error flag before the next request, fails the value checks.

// File: rtl/pws_pkg.sv
package pws_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_BREAK,
        ST_RECOV,
        ST_TX_SLOT,
        ST_RX_WAIT,
        ST_RX_SAMPLE,
        ST_FINISH
    } pws_state_e;

    function automatic int pws_max(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/pws_sync.sv
module pws_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout,
    output logic fall
);
    logic [STAGES-1:0] sh_q;
    logic              prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q   <= '1;
            prev_q <= 1'b1;
        end else begin
            sh_q   <= {sh_q[STAGES-2:0], din};
            prev_q <= sh_q[STAGES-1];
        end
    end

    assign dout = sh_q[STAGES-1];
    assign fall = prev_q & ~sh_q[STAGES-1];
endmodule

// File: rtl/pws_cnt.sv
module pws_cnt #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    output logic [W-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   q <= '0;
        else if (clr) q <= '0;
        else          q <= q + 1'b1;
    end
endmodule

// File: rtl/pw_serial_host.sv
module pw_serial_host
    import pws_pkg::*;
#(
    parameter int BREAK_CYC   = 40,
    parameter int RECOV_CYC   = 12,
    parameter int SLOT_CYC    = 40,
    parameter int LOW1_CYC    = 8,
    parameter int LOW0_CYC    = 24,
    parameter int SAMPLE_CYC  = 14,
    parameter int TIMEOUT_CYC = 200,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    input  logic [6:0] req_cmd,
    input  logic       req_rd,
    input  logic [7:0] req_wdata,
    output logic       busy,
    output logic       done,
    output logic [7:0] rd_data,
    output logic       err_timeout,
    output logic       line_oe,
    input  logic       line_in
);
    localparam int CNT_MAX = pws_max(pws_max(BREAK_CYC, RECOV_CYC),
                                     pws_max(pws_max(SLOT_CYC, SAMPLE_CYC), TIMEOUT_CYC));
    localparam int CW      = $clog2(CNT_MAX + 1);
    localparam int FRAME_W = 16;
    localparam int IDX_W   = $clog2(FRAME_W);

    pws_state_e        state_q, state_d;
    logic [CW-1:0]     cnt;
    logic              cnt_clr;
    logic              line_s, line_fall;
    logic [FRAME_W-1:0] frame_q;
    logic              is_rd_q;
    logic [IDX_W-1:0]  tx_idx_q;
    logic [6:0]        rx_sh_q;
    logic [2:0]        rx_idx_q;
    logic              err_q;
    logic [7:0]        rd_q;

    // events
    logic accept, brk_end, rec_end, slot_end, tx_last, tmo, samp_pt;
    logic [CW-1:0] cur_low;
    logic [7:0]    rx_new;

    pws_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(line_in), .dout(line_s), .fall(line_fall)
    );

    pws_cnt #(.W(CW)) u_cnt (
        .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .q(cnt)
    );

    assign accept   = (state_q == ST_IDLE) && req_valid;
    assign brk_end  = cnt == CW'(BREAK_CYC - 1);
    assign rec_end  = cnt == CW'(RECOV_CYC - 1);
    assign slot_end = cnt == CW'(SLOT_CYC - 1);
    assign tmo      = cnt == CW'(TIMEOUT_CYC - 1);
    assign samp_pt  = cnt == CW'(SAMPLE_CYC - 1);
    assign tx_last  = tx_idx_q == (is_rd_q ? IDX_W'(7) : IDX_W'(FRAME_W - 1));
    assign cur_low  = frame_q[tx_idx_q] ? CW'(LOW1_CYC) : CW'(LOW0_CYC);
    assign rx_new   = {line_s, rx_sh_q};

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      if (req_valid) state_d = ST_BREAK;
            ST_BREAK:     if (brk_end)   state_d = ST_RECOV;
            ST_RECOV:     if (rec_end)   state_d = ST_TX_SLOT;
            ST_TX_SLOT:   if (slot_end && tx_last)
                              state_d = is_rd_q ? ST_RX_WAIT : ST_FINISH;
            ST_RX_WAIT:   if (line_fall) state_d = ST_RX_SAMPLE;
                          else if (tmo)  state_d = ST_FINISH;
            ST_RX_SAMPLE: if (samp_pt)
                              state_d = (rx_idx_q == 3'd7) ? ST_FINISH : ST_RX_WAIT;
            ST_FINISH:    state_d = ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        cnt_clr     = (state_d != state_q) || (state_q == ST_IDLE)
                    || ((state_q == ST_TX_SLOT) && slot_end);
        busy        = state_q != ST_IDLE;
        done        = state_q == ST_FINISH;
        line_oe     = (state_q == ST_BREAK)
                    || ((state_q == ST_TX_SLOT) && (cnt < cur_low));
        rd_data     = rd_q;
        err_timeout = err_q;
    end

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            frame_q  <= '0;
            is_rd_q  <= 1'b0;
            tx_idx_q <= '0;
            rx_sh_q  <= '0;
            rx_idx_q <= '0;
            err_q    <= 1'b0;
            rd_q     <= '0;
        end else begin
            if (accept) begin
                frame_q  <= {req_wdata, req_rd, req_cmd};
                is_rd_q  <= req_rd;
                tx_idx_q <= '0;
                rx_idx_q <= '0;
                err_q    <= 1'b0;
            end
            if ((state_q == ST_TX_SLOT) && slot_end && !tx_last)
                tx_idx_q <= tx_idx_q + 1'b1;
            if ((state_q == ST_RX_WAIT) && !line_fall && tmo)
                err_q <= 1'b1;
            if ((state_q == ST_RX_SAMPLE) && samp_pt) begin
                rx_sh_q  <= rx_new[7:1];
                rx_idx_q <= rx_idx_q + 1'b1;
                if (rx_idx_q == 3'd7) rd_q <= rx_new;
            end
        end
    end
endmodule

// File: rtl/pws_checker.sv
module pws_checker (
    input logic clk,
    input logic rst_n,
    input logic req_valid,
    input logic busy,
    input logic done,
    input logic err_timeout,
    input logic line_oe
);
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R9
    AST_DONE_LAST_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy); // R9
    AST_ACCEPT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy) |=> busy); // R2
    AST_BREAK_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> line_oe); // R3
    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !line_oe); // R12
    AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_timeout) |-> done); // R8
    AST_ERR_CLEAR_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(err_timeout) |-> $rose(busy)); // R10
    AST_ERR_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !req_valid) |=> $stable(err_timeout)); // R10
endmodule

bind pw_serial_host pws_checker u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .busy(busy),
    .done(done), .err_timeout(err_timeout), .line_oe(line_oe)
);

// File: tb/pw_serial_host_tb.sv
module pw_serial_host_tb;
    localparam int B = 40, RC = 12, S = 40, L1 = 8, L0 = 24, SP = 14, TMO = 200;
    localparam int DW1 = 6, DW0 = 24, RSLOT = 40;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [6:0] req_cmd = '0;
    logic       req_rd = 1'b0;
    logic [7:0] req_wdata = '0;
    logic       busy, done, err_timeout, line_oe;
    logic [7:0] rd_data;
    logic       resp_oe = 1'b0;
    logic       line_in;
    assign line_in = !(line_oe || resp_oe);

    int checks = 0, errors = 0;
    logic [7:0] exp_rd = 8'h00;
    bit finished = 0;

    pw_serial_host #(.BREAK_CYC(B), .RECOV_CYC(RC), .SLOT_CYC(S), .LOW1_CYC(L1),
        .LOW0_CYC(L0), .SAMPLE_CYC(SP), .TIMEOUT_CYC(TMO), .SYNC_STAGES(2)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_cmd(req_cmd),
        .req_rd(req_rd), .req_wdata(req_wdata), .busy(busy), .done(done),
        .rd_data(rd_data), .err_timeout(err_timeout), .line_oe(line_oe),
        .line_in(line_in)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] frame(input logic [6:0] c, input bit rd,
                                          input logic [7:0] wd);
        return {wd, rd, c};
    endfunction

    task automatic run_len(input bit v, output int n);
        n = 0;
        while (line_oe == v && n < 2000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic respond(input logic [7:0] b, input int nbits);
        for (int i = 0; i < nbits; i++) begin
            int w;
            w = b[i] ? DW1 : DW0;
            resp_oe = 1'b1;
            repeat (w) @(negedge clk);
            resp_oe = 1'b0;
            repeat (RSLOT - w) @(negedge clk);
        end
    endtask

    task automatic do_txn(input logic [6:0] c, input bit rd, input logic [7:0] wd,
                          input logic [7:0] rb, input int nbits, input bit noise);
        logic [15:0] f;
        int n, w, nslots;
        f = frame(c, rd, wd);
        nslots = rd ? 8 : 16;
        @(negedge clk);
        req_valid = 1'b1; req_cmd = c; req_rd = rd; req_wdata = wd;
        @(negedge clk);
        if (noise) begin
            req_cmd = ~c; req_rd = !rd; req_wdata = ~wd;
        end else req_valid = 1'b0;
        chk(busy == 1'b1, "R2", "busy after request", busy, 1);
        chk(err_timeout == 1'b0, "R10", "error cleared on accept", err_timeout, 0);
        run_len(1'b1, n);
        req_valid = 1'b0;
        chk(n == B, "R3", "break length", n, B);
        run_len(1'b0, n);
        chk(n == RC, "R3", "recovery length", n, RC);
        w = 0;
        for (int s = 0; s < nslots; s++) begin
            w = f[s] ? L1 : L0;
            run_len(1'b1, n);
            if (s < 8) chk(n == w, "R4", $sformatf("command bit %0d low time", s), n, w);
            else       chk(n == w, "R6", $sformatf("data bit %0d low time", s - 8), n, w);
            if (s < nslots - 1) begin
                run_len(1'b0, n);
                chk(n == S - w, "R5", "slot released time", n, S - w);
            end
        end
        if (!rd) begin
            n = 0;
            while (!done && n < 2000) begin n++; @(negedge clk); end
            chk(n == S - w, "R6", "done after last write slot", n, S - w);
            chk(rd_data == exp_rd, "R11", "rd_data after write", rd_data, exp_rd);
            chk(err_timeout == 1'b0, "R8", "no error on write", err_timeout, 0);
            @(negedge clk);
            chk(done == 1'b0, "R9", "done one cycle", done, 0);
            chk(busy == 1'b0, "R9", "idle after done", busy, 0);
            chk(line_oe == 1'b0, "R12", "released when idle", line_oe, 0);
        end else begin
            logic [7:0] got_rd;
            bit got_err, hd, dn2, bsy2;
            hd = 0;
            fork
                begin
                    repeat (S - w + 3) @(negedge clk);
                    respond(rb, nbits);
                end
                begin
                    n = 0;
                    while (!done && n < 1200) begin
                        if (line_oe) hd = 1;
                        n++;
                        @(negedge clk);
                    end
                    got_rd = rd_data;
                    got_err = err_timeout;
                    @(negedge clk);
                    dn2 = done;
                    bsy2 = busy;
                end
            join
            chk(hd == 0, "R7", "host silent during read", hd, 0);
            if (nbits == 8) begin
                exp_rd = rb;
                chk(got_rd == rb, "R7", "read byte", got_rd, rb);
                chk(got_err == 1'b0, "R8", "no error on full read", got_err, 0);
            end else begin
                chk(got_err == 1'b1, "R8", "timeout flag", got_err, 1);
                chk(got_rd == exp_rd, "R8", "rd_data kept on timeout", got_rd, exp_rd);
            end
            chk(dn2 == 1'b0, "R9", "done one cycle", dn2, 0);
            chk(bsy2 == 1'b0, "R9", "idle after done", bsy2, 0);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL all watchdog expired: actual 1 expected 0");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(line_oe == 1'b0, "R1", "reset line_oe", line_oe, 0);
        chk(busy == 1'b0, "R1", "reset busy", busy, 0);
        chk(done == 1'b0, "R1", "reset done", done, 0);
        chk(err_timeout == 1'b0, "R1", "reset error", err_timeout, 0);
        chk(rd_data == 8'h00, "R1", "reset rd_data", rd_data, 0);

        do_txn(7'h00, 1'b0, 8'hFF, 8'h00, 8, 1'b0);
        do_txn(7'h7F, 1'b0, 8'h00, 8'h00, 8, 1'b0);
        do_txn(7'h2A, 1'b1, 8'h00, 8'hA5, 8, 1'b0);
        do_txn(7'h15, 1'b1, 8'h3C, 8'h81, 8, 1'b1);   // R2 noise while busy
        do_txn(7'h40, 1'b1, 8'h00, 8'hFF, 0, 1'b0);   // silent responder
        repeat (5) @(negedge clk);
        chk(err_timeout == 1'b1, "R10", "error held while idle", err_timeout, 1);
        chk(line_oe == 1'b0, "R12", "released when idle", line_oe, 0);
        do_txn(7'h01, 1'b1, 8'h00, 8'h5A, 3, 1'b0);   // partial response
        do_txn(7'h33, 1'b0, 8'hC3, 8'h00, 8, 1'b1);   // R11 write after error

        for (int k = 0; k < 20; k++) begin
            logic [6:0] c;
            logic [7:0] wd, rb;
            bit rd;
            int nb;
            c  = 7'($urandom);
            wd = 8'($urandom);
            rb = 8'($urandom);
            rd = 1'($urandom);
            nb = ($urandom % 6 == 0) ? 0 : 8;
            do_txn(c, rd, wd, rb, nb, 1'($urandom));
            repeat (1 + $urandom % 4) @(negedge clk);
        end

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule